// File: doc/BRIEF.md
# Logic BIST Run Sequencer

This block paces a logic built-in self-test run. Software or a boot controller programs a configuration word with a privileged write. The word sets how many intervals the run covers, how long to wait after scan enable rises before shift clocking begins, how many idle cycles surround the capture pulse, and where the run starts. A single-cycle `start` pulse then launches the run.

Each interval applies a parameterized number of patterns. A pattern is a shift phase followed by a capture phase. In the shift phase, scan enable is high; after the programmed gap, the functional clock enable and the MISR log enable run for a parameterized number of shift cycles. In the capture phase, scan enable is low and a single capture clock enable sits between two equal runs of idle cycles. The ROM address output names the current interval and advances by one per interval. After the last interval, `done` rises and the restart field of the configuration clears itself.

A run can start in three ways. It can continue after the last completed interval, restart at address 0, or begin at a segment index held in a separate preload register. The scan chains, the pattern source, the MISR arithmetic and the clock gating are outside this block.

Top module: `lbist_seq`

## Requirements
- R1: A run with interval count N (config bits [31:16], N ≥ 1) keeps `busy` high for exactly N·PATS·(G+SHIFT_LEN+2C+1) cycles, where G is config bits [7:5] and C is config bits [10:8]. `rom_addr` rises by one at each interval boundary, and at the end of the run it holds the index of the last interval executed.
- R2: A `start` pulse taken with interval count 0 does not begin a run. `busy` stays low, `rom_addr` is unchanged, and `err` is set. `err` clears on the next accepted start that has a nonzero count.
- R3: Every pattern opens with `scan_en` high for G+SHIFT_LEN cycles. `func_clk_en` and `misr_log_en` stay low for the first G of those cycles, then stay high for SHIFT_LEN cycles.
- R4: After the shift phase, `scan_en` is low for 2C+1 cycles. Within them, `func_clk_en` is high only in cycle C (counting from 0) and `misr_log_en` stays low throughout.
- R5: Restart field (config bits [1:0]) = 00 starts at the interval after the last completed one. If no run has completed since reset, it starts at 0.
- R6: Restart field = 01 starts the run at address 0.
- R7: Restart field = 1x starts the run at the index held in the preload register.
- R8: When a run completes, the restart field reads back as 00.
- R9: The configuration and preload registers change only when `cfg_priv` is high during a write. Reads are always available. Bits [15:11] and [4:2] read as zero. The configuration resets to 32'h0001_0120 (count 1, C=1, G=1, restart 00).
- R10: A `start` pulse that arrives while `busy` is high has no effect on the run.
- R11: `done` rises in the cycle `busy` falls after a completed run. It stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Privilege qualifier for both write strobes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| pl_we | input | 1 | Preload register write strobe |
| pl_wdata | input | 16 | Preload segment index |
| start | input | 1 | Single-cycle run launch |
| scan_en | output | 1 | Scan enable |
| func_clk_en | output | 1 | Shift and capture clock enable |
| misr_log_en | output | 1 | MISR logging enable |
| rom_addr | output | 16 | Current interval / ROM address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| err | output | 1 | Last start had an invalid count |

## Verification
The hardest case to reach is continue mode, because its expected start point depends on the history of earlier runs. The stimulus table is therefore ordered so that continue runs follow a fresh reset, a plain continue run, and preload runs with different segment indices, and each continue run is checked against the address the previous run left behind. Zero-gap settings (G=0, C=0) are mixed with the maximum of 7 to expose the boundary cases where a phase collapses to nothing. A second `start` pulse is injected in the middle of a run to check that the run is not disturbed.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int CNT_W  = 16;
  localparam int IDLE_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SGAP,
    PH_SHIFT,
    PH_CPRE,
    PH_CAP,
    PH_CPOST
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0]  n_int;
    logic [IDLE_W-1:0] cap_idle;
    logic [IDLE_W-1:0] se_idle;
    logic [1:0]        mode;
  } cfg_t;
endpackage

// File: rtl/lbist_cfg_reg.sv
module lbist_cfg_reg
  import lbist_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             priv,
  input  logic [31:0]      wdata,
  input  logic             pl_we,
  input  logic [CNT_W-1:0] pl_wdata,
  input  logic             mode_clr,
  output cfg_t             cfg,
  output logic [CNT_W-1:0] preload,
  output logic [31:0]      rdata
);
  cfg_t             cfg_d, cfg_q;
  logic [CNT_W-1:0] pl_d, pl_q;

  always_comb begin
    cfg_d = cfg_q;
    pl_d  = pl_q;
    if (we && priv) begin
      cfg_d.n_int    = wdata[31:16];
      cfg_d.cap_idle = wdata[10:8];
      cfg_d.se_idle  = wdata[7:5];
      cfg_d.mode     = wdata[1:0];
    end
    if (mode_clr) cfg_d.mode = 2'b00;
    if (pl_we && priv) pl_d = pl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.n_int    <= CNT_W'(1);
      cfg_q.cap_idle <= IDLE_W'(1);
      cfg_q.se_idle  <= IDLE_W'(1);
      cfg_q.mode     <= 2'b00;
      pl_q           <= '0;
    end else begin
      cfg_q <= cfg_d;
      pl_q  <= pl_d;
    end
  end

  assign cfg     = cfg_q;
  assign preload = pl_q;
  assign rdata   = {cfg_q.n_int, 5'b0, cfg_q.cap_idle, cfg_q.se_idle, 3'b0, cfg_q.mode};

  // R9: without a privileged write or a completion clear, the register holds
  p_priv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(we && priv) && !mode_clr) |=> $stable(rdata));
endmodule

// File: rtl/lbist_phase_fsm.sv
module lbist_phase_fsm
  import lbist_pkg::*;
#(
  parameter int SHIFT_LEN = 4,
  parameter int PATS      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              cont,
  input  logic [IDLE_W-1:0] se_idle,
  input  logic [IDLE_W-1:0] cap_idle,
  output logic              scan_en,
  output logic              func_clk_en,
  output logic              misr_log_en,
  output logic              busy,
  output logic              iv_end
);
  localparam int CYC_W = $clog2(SHIFT_LEN + (1 << IDLE_W)) + 1;
  localparam int PAT_W = $clog2(PATS + 1);

  phase_e           st_d, st_q;
  logic [CYC_W-1:0] cyc_d, cyc_q;
  logic [PAT_W-1:0] pat_d, pat_q;
  logic             pat_end;
  phase_e           sh_entry, cap_entry;
  logic [CYC_W-1:0] se_last, cap_last;

  assign sh_entry  = (se_idle  != '0) ? PH_SGAP : PH_SHIFT;
  assign cap_entry = (cap_idle != '0) ? PH_CPRE : PH_CAP;
  assign se_last   = CYC_W'(se_idle)  - CYC_W'(1);
  assign cap_last  = CYC_W'(cap_idle) - CYC_W'(1);

  always_comb begin
    st_d    = st_q;
    cyc_d   = cyc_q + CYC_W'(1);
    pat_d   = pat_q;
    pat_end = 1'b0;
    iv_end  = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        cyc_d = '0;
        if (launch) begin
          st_d  = sh_entry;
          pat_d = '0;
        end
      end
      PH_SGAP:  if (cyc_q == se_last) begin st_d = PH_SHIFT; cyc_d = '0; end
      PH_SHIFT: if (cyc_q == CYC_W'(SHIFT_LEN - 1)) begin st_d = cap_entry; cyc_d = '0; end
      PH_CPRE:  if (cyc_q == cap_last) begin st_d = PH_CAP; cyc_d = '0; end
      PH_CAP: begin
        cyc_d = '0;
        if (cap_idle != '0) st_d = PH_CPOST;
        else                pat_end = 1'b1;
      end
      PH_CPOST: if (cyc_q == cap_last) pat_end = 1'b1;
      default:  st_d = PH_IDLE;
    endcase
    if (pat_end) begin
      cyc_d = '0;
      if (pat_q == PAT_W'(PATS - 1)) begin
        iv_end = 1'b1;
        pat_d  = '0;
        st_d   = cont ? sh_entry : PH_IDLE;
      end else begin
        pat_d = pat_q + PAT_W'(1);
        st_d  = sh_entry;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cyc_q <= '0;
      pat_q <= '0;
    end else begin
      st_q  <= st_d;
      cyc_q <= cyc_d;
      pat_q <= pat_d;
    end
  end

  assign scan_en     = (st_q == PH_SGAP) || (st_q == PH_SHIFT);
  assign func_clk_en = (st_q == PH_SHIFT) || (st_q == PH_CAP);
  assign misr_log_en = (st_q == PH_SHIFT);
  assign busy        = (st_q != PH_IDLE);

  // R3: MISR logging only happens while shifting with the shift clock on
  p_misr_in_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    misr_log_en |-> (scan_en && func_clk_en));
  // R4: the capture clock enable is a single-cycle pulse
  p_cap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (func_clk_en && !scan_en) |=> !(func_clk_en && !scan_en));
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int SHIFT_LEN = 4,
  parameter int PATS      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_priv,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        pl_we,
  input  logic [15:0] pl_wdata,
  input  logic        start,
  output logic        scan_en,
  output logic        func_clk_en,
  output logic        misr_log_en,
  output logic [15:0] rom_addr,
  output logic        busy,
  output logic        done,
  output logic        err
);
  cfg_t             cfg;
  logic [CNT_W-1:0] preload;
  logic             accept, launch, iv_end, last_iv, mode_clr;
  logic [CNT_W-1:0] rom_d, rom_q, left_d, left_q;
  logic             done_d, done_q, err_d, err_q, ran_d, ran_q;

  lbist_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .priv     (cfg_priv),
    .wdata    (cfg_wdata),
    .pl_we    (pl_we),
    .pl_wdata (pl_wdata),
    .mode_clr (mode_clr),
    .cfg      (cfg),
    .preload  (preload),
    .rdata    (cfg_rdata)
  );

  lbist_phase_fsm #(.SHIFT_LEN(SHIFT_LEN), .PATS(PATS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .cont        (!last_iv),
    .se_idle     (cfg.se_idle),
    .cap_idle    (cfg.cap_idle),
    .scan_en     (scan_en),
    .func_clk_en (func_clk_en),
    .misr_log_en (misr_log_en),
    .busy        (busy),
    .iv_end      (iv_end)
  );

  assign accept   = start && !busy;
  assign launch   = accept && (cfg.n_int != '0);
  assign last_iv  = (left_q == CNT_W'(1));
  assign mode_clr = iv_end && last_iv;

  always_comb begin
    rom_d  = rom_q;
    left_d = left_q;
    done_d = done_q;
    err_d  = err_q;
    ran_d  = ran_q;
    if (accept) begin
      done_d = 1'b0;
      err_d  = (cfg.n_int == '0);
      if (launch) begin
        left_d = cfg.n_int;
        if (cfg.mode[1])      rom_d = preload;
        else if (cfg.mode[0]) rom_d = '0;
        else                  rom_d = ran_q ? rom_q + CNT_W'(1) : '0;
      end
    end
    if (iv_end) begin
      if (last_iv) begin
        done_d = 1'b1;
        ran_d  = 1'b1;
      end else begin
        left_d = left_q - CNT_W'(1);
        rom_d  = rom_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_q  <= '0;
      left_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ran_q  <= 1'b0;
    end else begin
      rom_q  <= rom_d;
      left_q <= left_d;
      done_q <= done_d;
      err_q  <= err_d;
      ran_q  <= ran_d;
    end
  end

  assign rom_addr = rom_q;
  assign done     = done_q;
  assign err      = err_q;

  // R1: during a run the address only holds or steps up by one
  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rom_addr == $past(rom_addr) || rom_addr == $past(rom_addr) + 16'd1));
  // R2: a start with a zero count flags an error and does not run
  p_zero_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_rdata[31:16] == 16'd0) |=> (err && !busy));
  // R11: done is never raised during a run
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/lbist_seq_test.sv
module lbist_seq_test;
  localparam int SL = 4;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0, pl_we = 1'b0, start = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] pl_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        scan_en, func_clk_en, misr_log_en, busy, done, err;
  logic [15:0] rom_addr;

  int checks = 0;
  int fails  = 0;

  always #5ns clk = ~clk;

  lbist_seq #(.SHIFT_LEN(SL), .PATS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pl_we(pl_we), .pl_wdata(pl_wdata),
    .start(start), .scan_en(scan_en), .func_clk_en(func_clk_en),
    .misr_log_en(misr_log_en), .rom_addr(rom_addr), .busy(busy), .done(done), .err(err)
  );

  // {count, cap idle, se idle, mode, preload, first addr, last addr}
  localparam logic [71:0] VEC [6] = '{
    {16'd3, 3'd1, 3'd1, 2'd0, 16'd0,  16'd0,  16'd2},
    {16'd2, 3'd0, 3'd0, 2'd0, 16'd0,  16'd3,  16'd4},
    {16'd1, 3'd2, 3'd3, 2'd1, 16'd0,  16'd0,  16'd0},
    {16'd4, 3'd7, 3'd7, 2'd2, 16'd10, 16'd10, 16'd13},
    {16'd1, 3'd0, 3'd2, 2'd3, 16'd5,  16'd5,  16'd5},
    {16'd2, 3'd3, 3'd0, 2'd0, 16'd0,  16'd6,  16'd7}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] d, input logic p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = p; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic wr_pl(input logic [15:0] d);
    @(negedge clk);
    pl_we = 1'b1; cfg_priv = 1'b1; pl_wdata = d;
    @(negedge clk);
    pl_we = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset value and idle outputs
    chk(cfg_rdata == 32'h0001_0120, "R9 reset cfg", cfg_rdata, 32'h0001_0120);
    chk({scan_en, func_clk_en, misr_log_en, busy, done, err} == 6'b0, "R11 reset outputs",
        {scan_en, func_clk_en, misr_log_en, busy, done, err}, 0);
    // R9 unprivileged write ignored
    wr_cfg(32'hFFFF_FFFF, 1'b0);
    chk(cfg_rdata == 32'h0001_0120, "R9 unprivileged write", cfg_rdata, 32'h0001_0120);
    // R9 reserved bits read zero
    wr_cfg(32'hFFFF_FFFF, 1'b1);
    chk(cfg_rdata == 32'hFFFF_07E3, "R9 reserved bits", cfg_rdata, 32'hFFFF_07E3);
    // R2 zero count
    wr_cfg(32'h0000_0120, 1'b1);
    pulse_start();
    chk(err == 1'b1, "R2 err set", err, 1);
    chk(busy == 1'b0 && scan_en == 1'b0, "R2 no run", busy, 0);
    chk(rom_addr == 16'd0, "R2 addr kept", rom_addr, 0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic [71:0] e;
      int n, c, s, expc, cyc, sc, fc, mc, gse, gc, tsc, tfall, first, last;
      bit seen, prev;
      e = VEC[v];
      n = int'(e[71:56]); c = int'(e[55:53]); s = int'(e[52:50]);
      wr_pl(e[47:32]);
      wr_cfg({e[71:56], 5'b0, e[55:53], e[52:50], 3'b0, e[49:48]}, 1'b1);
      pulse_start();
      expc = n * NP * (s + SL + 2 * c + 1);
      cyc = 0; sc = 0; fc = 0; mc = 0; gse = -1; gc = -1; tsc = 0; tfall = -1;
      seen = 1'b0; prev = 1'b0; first = int'(rom_addr); last = first;
      while (busy && cyc < 5000) begin
        if (scan_en) sc++;
        if (func_clk_en) fc++;
        if (misr_log_en) mc++;
        if (scan_en && !seen) begin seen = 1'b1; tsc = cyc; end
        if (func_clk_en && seen && gse < 0) gse = cyc - tsc;
        if (prev && !scan_en && tfall < 0) tfall = cyc;
        if (tfall >= 0 && func_clk_en && !scan_en && gc < 0) gc = cyc - tfall;
        prev = scan_en;
        last = int'(rom_addr);
        cyc++;
        @(negedge clk);
      end
      chk(first == int'(e[31:16]), "R5/R6/R7 start addr", first, e[31:16]);
      chk(last == int'(e[15:0]), "R1 last addr", last, e[15:0]);
      chk(cyc == expc, "R1 run length", cyc, expc);
      chk(sc == n * NP * (s + SL), "R3 scan_en cycles", sc, n * NP * (s + SL));
      chk(mc == n * NP * SL, "R3 misr cycles", mc, n * NP * SL);
      chk(fc == n * NP * (SL + 1), "R4 func clk cycles", fc, n * NP * (SL + 1));
      chk(gse == s, "R3 shift gap", gse, s);
      chk(gc == c, "R4 capture gap", gc, c);
      chk(done == 1'b1 && err == 1'b0, "R11 done after run", {done, err}, 2);
      chk(cfg_rdata[1:0] == 2'b00, "R8 mode cleared", cfg_rdata[1:0], 0);
    end

    // R10 start while busy ignored
    begin
      int cyc;
      wr_cfg({16'd2, 5'b0, 3'd1, 3'd1, 3'b0, 2'b01}, 1'b1);
      pulse_start();
      cyc = 0;
      while (busy && cyc < 5000) begin
        start = (cyc == 5);
        cyc++;
        @(negedge clk);
      end
      start = 1'b0;
      chk(cyc == 32, "R10 run length with extra start", cyc, 32);
      chk(rom_addr == 16'd1, "R10 last addr", rom_addr, 1);
    end
    // R11 done persists
    repeat (10) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R11 done held", done, 1);
    // R2 / R11 zero-count start clears done, sets err
    wr_cfg(32'h0000_0120, 1'b1);
    pulse_start();
    chk(done == 1'b0, "R11 done cleared by start", done, 0);
    chk(err == 1'b1 && busy == 1'b0, "R2 err on second zero start", err, 1);
    chk(rom_addr == 16'd1, "R2 addr unchanged", rom_addr, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule